// File: doc/BRIEF.md
# Automatic Level Control Gain Sequencer

This block is the digital sequencer behind an automatic level controller that drives a 7-bit input gain stage. Once per sample period it receives a strobe together with three flags from external detectors. The first flag says the signal is at or above the limit threshold. The second says it is below the recovery reset level. The third marks a zero crossing. From these flags the block decides when to cut the gain and when to raise it again.

When the signal is too loud, the gain is reduced by a programmable number of codes. The cut happens either at once or, in zero-cross mode, at the next zero crossing. A timeout forces the cut if no crossing arrives in time. When the signal stays quiet for a programmable number of sample periods, the gain is raised by one or two codes. It is never raised past a programmable ceiling.

All settings are captured only while the function is disabled. Clearing the enable freezes the gain at its last value.

Top module: `alc_gain_seq`

## Requirements
- R1: After reset the gain output is 64 and the phase output is 00 (off) while the enable is low.
- R2: With zero-cross mode off, a strobed sample with the over flag set lowers the gain at that same clock edge, and the phase reads 01 (running).
- R3: The limiter select value 0, 1, 2 or 3 reduces the gain by 1, 2, 3 or 4 codes per limiting event.
- R4: A reduction never takes the gain below 0; it saturates at 0.
- R5: With zero-cross mode on, an over sample arms a pending cut, and the phase reads 10 while the cut is armed. The cut is applied on the first later strobed sample that has the zero-cross flag set, and the phase then returns to 01.
- R6: If no crossing arrives, an armed cut is applied on the Nth strobed sample after arming. N is 128, 256, 512 or 1024 for timeout select 0, 1, 2 or 3.
- R7: A recovery step happens on the Lth consecutive strobed sample that has the low flag set and no limiting activity. L is 128, 256, 512 or 1024 for wait select 0, 1, 2 or 3.
- R8: The wait count restarts from zero after any strobed sample without the low flag, and after any sample that carries limiting activity.
- R9: A recovery step adds 1 code when the recovery select is 0 and 2 codes when it is 1.
- R10: Recovery clamps the gain at the ceiling value. If the gain is already at or above the ceiling, recovery leaves it unchanged.
- R11: While the enable is low the gain holds its last value and the phase reads 00. Disabling also discards an armed cut and the wait count.
- R12: Setting inputs are captured only while the enable is low. Changes made while it is high have no effect.
- R13: The gain never changes on a clock edge without the sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| alc_en | input | 1 | Enables the automatic gain sequencing |
| lvl_over | input | 1 | Sample level at or above limit threshold |
| lvl_low | input | 1 | Sample level below recovery reset level |
| zc_det | input | 1 | Zero crossing seen in this sample |
| lim_sel | input | 2 | Limiter step select (1 to 4 codes) |
| rec_sel | input | 1 | Recovery step select (1 or 2 codes) |
| ceil_gain | input | 7 | Recovery ceiling gain code |
| wait_sel | input | 2 | Recovery wait period select |
| zc_mode | input | 1 | Defer cuts to zero crossings |
| tmo_sel | input | 2 | Zero-cross timeout select |
| gain | output | 7 | Gain code to the analog stage |
| phase | output | 2 | 00 off, 01 running, 10 cut armed |

## Verification
On every cycle, the assertions check several properties. The gain stays still on edges without the strobe and while disabled. A limiting event and a recovery event never coincide. Every limiting event lowers the gain or leaves it at 0. Every recovery event raises it by at most two codes and never past the ceiling.

Some behaviours only the bench's scenarios can show, because they depend on exact sample counts or on the absence of an effect. These are the exact wait and timeout lengths for each select value, and the restart of the wait count. They also include the step sizes per select value, the freezing of settings while enabled, and the discarding of an armed cut on disable.

// File: rtl/alc_seq_pkg.sv
package alc_seq_pkg;
  localparam int GAIN_W = 7;

  typedef enum logic [1:0] {
    PH_OFF  = 2'b00,
    PH_RUN  = 2'b01,
    PH_PEND = 2'b10
  } phase_e;

  typedef struct packed {
    logic [1:0]        lim_sel;
    logic              rec_sel;
    logic [GAIN_W-1:0] ceil;
    logic [1:0]        wait_sel;
    logic              zc_mode;
    logic [1:0]        tmo_sel;
  } cfg_t;

  // Window length in samples: base doubled per select step.
  function automatic int unsigned span(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

  // Saturating reduction by sel+1 codes.
  function automatic logic [GAIN_W-1:0] lim_down(input logic [GAIN_W-1:0] g,
                                                 input logic [1:0] sel);
    logic [GAIN_W:0] amt;
    amt = {{(GAIN_W-1){1'b0}}, sel} + 1'b1;
    if ({1'b0, g} <= amt) return '0;
    return g - amt[GAIN_W-1:0];
  endfunction

  // Raise by 1 or 2 codes, clamped at the ceiling, hold at or above it.
  function automatic logic [GAIN_W-1:0] up_clamp(input logic [GAIN_W-1:0] g,
                                                 input logic rsel,
                                                 input logic [GAIN_W-1:0] ceil);
    logic [GAIN_W:0] s;
    s = {1'b0, g} + {{(GAIN_W-1){1'b0}}, rsel, ~rsel};
    if (g >= ceil) return g;
    if (s > {1'b0, ceil}) return ceil;
    return s[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/alc_cfg_hold.sv
module alc_cfg_hold
  import alc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (!en) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/alc_lim_ctrl.sv
module alc_lim_ctrl
  import alc_seq_pkg::*;
#(
  parameter int unsigned TMO_BASE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       act,
  input  logic       over,
  input  logic       zc,
  input  logic       zc_mode,
  input  logic [1:0] tmo_sel,
  output logic       lim_fire,
  output logic       pend,
  output logic       busy
);
  localparam int CW = $clog2(TMO_BASE * 8);

  logic          pend_q;
  logic [CW-1:0] tcnt;
  logic          tmo_end;

  assign tmo_end = (tcnt == CW'(span(TMO_BASE, tmo_sel) - 1));
  assign pend    = pend_q;
  assign busy    = act & (over | pend_q);

  always_comb begin
    lim_fire = 1'b0;
    if (act) begin
      if (!zc_mode)    lim_fire = over;
      else if (pend_q) lim_fire = zc | tmo_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tcnt   <= '0;
    end else if (!en) begin
      pend_q <= 1'b0;
      tcnt   <= '0;
    end else if (act && zc_mode) begin
      if (pend_q) begin
        if (zc || tmo_end) begin
          pend_q <= 1'b0;
          tcnt   <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end else if (over) begin
        pend_q <= 1'b1;
        tcnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/alc_wait_timer.sv
module alc_wait_timer
  import alc_seq_pkg::*;
#(
  parameter int unsigned WAIT_BASE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       act,
  input  logic       low,
  input  logic       busy,
  input  logic [1:0] wait_sel,
  output logic       rec_fire
);
  localparam int CW = $clog2(WAIT_BASE * 8);

  logic [CW-1:0] wcnt;
  logic          wend;

  assign wend     = (wcnt == CW'(span(WAIT_BASE, wait_sel) - 1));
  assign rec_fire = act & low & ~busy & wend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wcnt <= '0;
    else if (!en)              wcnt <= '0;
    else if (act) begin
      if (busy || !low)        wcnt <= '0;
      else if (wend)           wcnt <= '0;
      else                     wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/alc_gain_reg.sv
module alc_gain_reg
  import alc_seq_pkg::*;
#(
  parameter logic [GAIN_W-1:0] RST_GAIN = 7'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_fire,
  input  logic              rec_fire,
  input  logic [1:0]        lim_sel,
  input  logic              rec_sel,
  input  logic [GAIN_W-1:0] ceil,
  output logic [GAIN_W-1:0] gain
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain <= RST_GAIN;
    else if (lim_fire) gain <= lim_down(gain, lim_sel);
    else if (rec_fire) gain <= up_clamp(gain, rec_sel, ceil);
  end
endmodule

// File: rtl/alc_gain_seq.sv
module alc_gain_seq
  import alc_seq_pkg::*;
#(
  parameter int unsigned       WAIT_BASE = 128,
  parameter int unsigned       TMO_BASE  = 128,
  parameter logic [GAIN_W-1:0] RST_GAIN  = 7'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic              alc_en,
  input  logic              lvl_over,
  input  logic              lvl_low,
  input  logic              zc_det,
  input  logic [1:0]        lim_sel,
  input  logic              rec_sel,
  input  logic [GAIN_W-1:0] ceil_gain,
  input  logic [1:0]        wait_sel,
  input  logic              zc_mode,
  input  logic [1:0]        tmo_sel,
  output logic [GAIN_W-1:0] gain,
  output logic [1:0]        phase
);
  cfg_t cfg_in, cfg_q;
  logic act, lim_fire, rec_fire, pend, busy;
  logic [GAIN_W-1:0] ceil_q;

  assign cfg_in = '{lim_sel: lim_sel, rec_sel: rec_sel, ceil: ceil_gain,
                    wait_sel: wait_sel, zc_mode: zc_mode, tmo_sel: tmo_sel};
  assign act    = fs_tick & alc_en;
  assign ceil_q = cfg_q.ceil;

  alc_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .en(alc_en), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  alc_lim_ctrl #(.TMO_BASE(TMO_BASE)) u_lim (
    .clk(clk), .rst_n(rst_n), .en(alc_en), .act(act), .over(lvl_over),
    .zc(zc_det), .zc_mode(cfg_q.zc_mode), .tmo_sel(cfg_q.tmo_sel),
    .lim_fire(lim_fire), .pend(pend), .busy(busy)
  );

  alc_wait_timer #(.WAIT_BASE(WAIT_BASE)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(alc_en), .act(act), .low(lvl_low),
    .busy(busy), .wait_sel(cfg_q.wait_sel), .rec_fire(rec_fire)
  );

  alc_gain_reg #(.RST_GAIN(RST_GAIN)) u_gain (
    .clk(clk), .rst_n(rst_n), .lim_fire(lim_fire), .rec_fire(rec_fire),
    .lim_sel(cfg_q.lim_sel), .rec_sel(cfg_q.rec_sel), .ceil(cfg_q.ceil),
    .gain(gain)
  );

  always_comb begin
    if (!alc_en)   phase = PH_OFF;
    else if (pend) phase = PH_PEND;
    else           phase = PH_RUN;
  end
endmodule

// File: rtl/alc_gain_seq_chk.sv
module alc_gain_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_tick,
  input logic       alc_en,
  input logic [6:0] gain,
  input logic [6:0] ceil_q,
  input logic       lim_fire,
  input logic       rec_fire
);
  a_r13_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_tick |=> $stable(gain));

  a_r11_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alc_en |=> $stable(gain));

  a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lim_fire && rec_fire));

  a_r4_limit_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    lim_fire |=> (gain < $past(gain)) || ($past(gain) == 7'd0));

  a_r9_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fire |=> (gain >= $past(gain)) && ({1'b0, gain} <= {1'b0, $past(gain)} + 8'd2));

  a_r10_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_fire && gain < ceil_q) |=> gain <= ceil_q);
endmodule

bind alc_gain_seq alc_gain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .alc_en(alc_en),
  .gain(gain), .ceil_q(ceil_q), .lim_fire(lim_fire), .rec_fire(rec_fire)
);

// File: tb/alc_gain_seq_bench.sv
module alc_gain_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, en = 1'b0, over = 1'b0, low = 1'b0, zc = 1'b0;
  logic [1:0] lsel = '0, wsel = '0, tsel = '0;
  logic       rsel = 1'b0, zm = 1'b0;
  logic [6:0] ceil = 7'd100;
  logic [6:0] gain;
  logic [1:0] phase;

  int n_tests = 0, n_fail = 0, g = 64;
  bit done = 0;

  always #5 clk = ~clk;

  alc_gain_seq u_alc_gain_seq (
    .clk(clk), .rst_n(rst_n), .fs_tick(tick), .alc_en(en), .lvl_over(over),
    .lvl_low(low), .zc_det(zc), .lim_sel(lsel), .rec_sel(rsel),
    .ceil_gain(ceil), .wait_sel(wsel), .zc_mode(zm), .tmo_sel(tsel),
    .gain(gain), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tk(input bit o, input bit l, input bit z);
    @(negedge clk);
    over = o; low = l; zc = z; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; over = 1'b0; low = 1'b0; zc = 1'b0;
  endtask

  task automatic ticks(input int n, input bit o, input bit l, input bit z);
    for (int i = 0; i < n; i++) tk(o, l, z);
  endtask

  task automatic setup(input int ls, input bit rs, input int c, input int ws,
                       input bit zmode, input int ts);
    @(negedge clk);
    en = 1'b0;
    lsel = 2'(ls); rsel = rs; ceil = 7'(c); wsel = 2'(ws); zm = zmode; tsel = 2'(ts);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 reset gain", int'(gain), 64);
    chk("R1 reset phase", int'(phase), 0);
  endtask

  task automatic t_limit_steps;
    for (int s = 0; s < 4; s++) begin
      setup(s, 0, 100, 0, 0, 0);
      tk(1, 0, 0);
      g = g - (s + 1);
      chk("R3 limiter step size", int'(gain), g);
      if (s == 0) chk("R2 running phase", int'(phase), 1);
    end
  endtask

  task automatic t_cfg_frozen;
    setup(0, 0, 100, 0, 0, 0);
    @(negedge clk);
    lsel = 2'd3;
    tk(1, 0, 0);
    g = g - 1;
    chk("R12 setting frozen while enabled", int'(gain), g);
  endtask

  task automatic t_floor;
    setup(3, 0, 100, 0, 0, 0);
    ticks(14, 1, 0, 0);
    g = 0;
    chk("R4 floor at zero", int'(gain), 0);
    tk(1, 0, 0);
    chk("R4 stays at zero", int'(gain), 0);
  endtask

  task automatic t_wait;
    setup(0, 0, 10, 0, 0, 0);
    ticks(127, 0, 1, 0);
    chk("R7 no step before 128", int'(gain), g);
    tk(0, 1, 0);
    g = g + 1;
    chk("R7 step at 128", int'(gain), g);
    ticks(100, 0, 1, 0);
    tk(0, 0, 0);
    ticks(127, 0, 1, 0);
    chk("R8 restart after loud sample", int'(gain), g);
    tk(0, 1, 0);
    g = g + 1;
    chk("R8 step after full restart", int'(gain), g);
    ticks(100, 0, 1, 0);
    tk(1, 1, 0);
    g = g - 1;
    ticks(127, 0, 1, 0);
    chk("R8 restart after limit", int'(gain), g);
    tk(0, 1, 0);
    g = g + 1;
    chk("R8 step after limit restart", int'(gain), g);
  endtask

  task automatic t_step_two;
    setup(0, 1, 10, 0, 0, 0);
    ticks(128, 0, 1, 0);
    g = g + 2;
    chk("R9 two-code step", int'(gain), g);
  endtask

  task automatic t_ceiling;
    setup(0, 1, 5, 0, 0, 0);
    ticks(128, 0, 1, 0);
    g = 5;
    chk("R10 clamp at ceiling", int'(gain), 5);
    ticks(128, 0, 1, 0);
    chk("R10 hold at ceiling", int'(gain), 5);
  endtask

  task automatic t_wait_sel;
    for (int w = 1; w < 4; w++) begin
      setup(0, 0, 20, w, 0, 0);
      ticks((128 << w) - 1, 0, 1, 0);
      chk("R7 no step before window", int'(gain), g);
      tk(0, 1, 0);
      g = g + 1;
      chk("R7 step at window end", int'(gain), g);
    end
  endtask

  task automatic t_zero_cross;
    setup(1, 0, 20, 0, 1, 0);
    tk(1, 0, 0);
    chk("R5 cut deferred", int'(gain), g);
    chk("R5 armed phase", int'(phase), 2);
    ticks(3, 0, 0, 0);
    chk("R5 waits for crossing", int'(gain), g);
    tk(0, 0, 1);
    g = g - 2;
    chk("R5 cut at crossing", int'(gain), g);
    chk("R5 phase back to running", int'(phase), 1);
  endtask

  task automatic t_timeout;
    setup(0, 0, 20, 0, 1, 1);
    tk(1, 0, 0);
    ticks(255, 0, 0, 0);
    chk("R6 no cut before timeout", int'(gain), g);
    chk("R6 still armed", int'(phase), 2);
    tk(0, 0, 0);
    g = g - 1;
    chk("R6 cut at timeout", int'(gain), g);
    chk("R6 phase after timeout", int'(phase), 1);
  endtask

  task automatic t_disable;
    setup(0, 0, 20, 0, 1, 0);
    tk(1, 0, 0);
    @(negedge clk);
    en = 1'b0;
    ticks(3, 1, 1, 1);
    chk("R11 gain held while off", int'(gain), g);
    chk("R11 phase off", int'(phase), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R11 armed cut discarded", int'(phase), 1);
    tk(0, 0, 1);
    chk("R11 no cut after re-enable", int'(gain), g);
  endtask

  task automatic t_no_tick;
    setup(3, 0, 20, 0, 0, 0);
    @(negedge clk);
    over = 1'b1; low = 1'b1; zc = 1'b1;
    repeat (20) @(negedge clk);
    over = 1'b0; low = 1'b0; zc = 1'b0;
    chk("R13 no change without strobe", int'(gain), g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_limit_steps;
    t_cfg_frozen;
    t_floor;
    t_wait;
    t_step_two;
    t_ceiling;
    t_wait_sel;
    t_zero_cross;
    t_timeout;
    t_disable;
    t_no_tick;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule